// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Double-Buffered Compare

This block produces a symmetric, center-aligned pulse-width-modulated signal. A time-base counter climbs from zero to a programmed period value and then falls back to zero, so one carrier cycle lasts twice the period value in clock cycles. For example, a 5 kHz carrier needs a period value of f_clk / 10 kHz. Channel A is driven high when the counter meets compare A on the rising slope. It is driven low when the counter meets compare A on the falling slope. The result is a pulse centred on the counter peak.

Each of the two compare values can be written in one of two ways. In buffered mode a write lands in a holding register. The holding register is copied into the working register only at the counter-zero event, so a new duty takes effect at the start of the next full up-down cycle and never partway through one. In direct mode a write reaches the working register on the next clock. A pending flag per compare shows that a buffered value is waiting. Compare B does not drive a pin. It produces a match strobe that other logic can use for triggering. A start-of-conversion strobe is raised while the counter sits at zero. A global enable freezes the whole time base while low.

Top module: `cpwm_core`

## Requirements
- R1: After reset the counter reads 0, the direction reads up (dir_down = 0), pwm_a is low, both pending flags are clear, and both working compare values are 0.
- R2: While enabled with period P > 0, the counter steps 0,1,…,P,P−1,…,1,0,1,… so that one carrier cycle lasts 2P clocks. dir_down is 1 at the count P and on every value of the falling slope down to 1. It is 0 at 0 and on the rising slope.
- R3: While tb_en is low, the counter, the direction and pwm_a keep their values.
- R4: With a working compare C where 0 < C < P, pwm_a rises on the clock after the counter equals C on the rising slope. It falls on the clock after the counter equals C on the falling slope. It is therefore high for 2(P−C) clocks of each 2P-clock cycle.
- R5: A working compare of 0 keeps pwm_a high for the whole cycle. A working compare equal to or above P keeps pwm_a low for the whole cycle.
- R6: With shadow_mode = 1, a compare write does not change the working value. The working value takes the last value written, at the first enabled counter-zero cycle after the write.
- R7: With shadow_mode = 0, a compare write sets the working value on the next clock and discards any value still pending for that compare.
- R8: A buffered write sets that compare's pending flag on the next clock. The flag clears on the clock after an enabled counter-zero cycle in which no new write arrives.
- R9: soc is high exactly in the cycles where tb_en is high and the counter is 0. That gives one pulse per carrier cycle.
- R10: cmpb_match is high in the cycles where tb_en is high and the counter equals the working compare B. For 0 < B < P that happens twice per carrier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | Global time-base enable; counter frozen while low |
| period | input | CNT_W | Peak count value P |
| shadow_mode | input | 1 | 1: buffered compare writes; 0: direct writes |
| cmpa_wr | input | 1 | Write strobe for compare A |
| cmpa_data | input | CNT_W | Compare A write value |
| cmpb_wr | input | 1 | Write strobe for compare B |
| cmpb_data | input | CNT_W | Compare B write value |
| pwm_a | output | 1 | Channel A waveform |
| count | output | CNT_W | Time-base counter value |
| dir_down | output | 1 | Counter direction, 1 while on the falling slope |
| soc | output | 1 | Start-of-conversion strobe at counter zero |
| cmpb_match | output | 1 | Counter equals working compare B |
| pend_a | output | 1 | Compare A buffered value waiting |
| pend_b | output | 1 | Compare B buffered value waiting |

## Verification
The counter, direction and pending flags take their new values at the first rising edge after the inputs that cause them. pwm_a adds one more register, so it moves one clock after the counter shows the matching value. soc and cmpb_match are decoded directly from registered state, so they are valid in the same cycle as the count they describe. A buffered duty appears on pwm_a only in the carrier cycle that follows the next zero event.

The scoreboard steps its own model once per driven cycle and queues the values expected after the coming edge. The monitor compares them a fifth of a period after that edge. The duty checks count high cycles only across a complete 2P window that begins at the second soc after a change, so that the new duty is in force for the whole window.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_evt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_dec;

    assign cnt_inc = st_q.cnt + ONE;
    assign cnt_dec = st_q.cnt - ONE;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (st_q.dir == DIR_UP) begin
                if (period == '0) begin
                    st_d.cnt = '0;
                    st_d.dir = DIR_UP;
                end else if (st_q.cnt >= period) begin
                    st_d.cnt = cnt_dec;
                    st_d.dir = (st_q.cnt == ONE) ? DIR_UP : DIR_DOWN;
                end else begin
                    st_d.cnt = cnt_inc;
                    st_d.dir = (cnt_inc >= period) ? DIR_DOWN : DIR_UP;
                end
            end else begin
                if (st_q.cnt <= ONE) begin
                    st_d.cnt = '0;
                    st_d.dir = DIR_UP;
                end else begin
                    st_d.cnt = cnt_dec;
                    st_d.dir = DIR_DOWN;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign dir_down = (st_q.dir == DIR_DOWN);
    assign zero_evt = run && (st_q.cnt == '0);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(count) && $stable(dir_down)));

    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !dir_down && (count < period)) |=> (count == $past(count) + ONE));

    p_bottom_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir_down && (count == ONE)) |=> (count == '0 && !dir_down));

    p_soc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && (period != '0)) |=> !zero_evt);
endmodule

// File: rtl/cpwm_cmpbuf.sv
module cpwm_cmpbuf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shadow_mode,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load_evt,
    output logic [CNT_W-1:0] active,
    output logic             pending
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] work;
        logic             pend;
    } buf_state_t;

    buf_state_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (load_evt && bs_q.pend) begin
            bs_d.work = bs_q.shadow;
            bs_d.pend = 1'b0;
        end
        if (wr) begin
            if (shadow_mode) begin
                bs_d.shadow = wdata;
                bs_d.pend   = 1'b1;
            end else begin
                bs_d.work   = wdata;
                bs_d.shadow = wdata;
                bs_d.pend   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '{shadow: '0, work: '0, pend: 1'b0};
        end else begin
            bs_q <= bs_d;
        end
    end

    assign active  = bs_q.work;
    assign pending = bs_q.pend;

    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && !(wr && !shadow_mode)) |=> $stable(active));

    p_direct_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !shadow_mode) |=> (active == $past(wdata) && !pending));

    p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && shadow_mode) |=> pending);

    p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && !wr) |=> !pending);
endmodule

// File: rtl/cpwm_action.sv
module cpwm_action #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm
);
    typedef struct packed {
        logic out;
    } act_state_t;

    act_state_t as_d, as_q;
    logic [CNT_W-1:0] clr_point;
    logic             set_hit;
    logic             clr_hit;

    assign clr_point = (cmp >= period) ? period : cmp;
    assign set_hit   = run && !dir_down && (count == cmp) && (cmp < period);
    assign clr_hit   = run && dir_down && (count == clr_point);

    always_comb begin
        as_d = as_q;
        if (set_hit) begin
            as_d.out = 1'b1;
        end else if (clr_hit) begin
            as_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q <= '{out: 1'b0};
        end else begin
            as_q <= as_d;
        end
    end

    assign pwm = as_q.out;

    p_rise_on_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> $past(!dir_down && run));

    p_fall_on_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm) |-> $past(dir_down && run));

    p_full_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && (cmp >= period)) |=> !pwm);
endmodule

// File: rtl/cpwm_core.sv
module cpwm_core
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_en,
    input  logic [CNT_W-1:0] period,
    input  logic             shadow_mode,
    input  logic             cmpa_wr,
    input  logic [CNT_W-1:0] cmpa_data,
    input  logic             cmpb_wr,
    input  logic [CNT_W-1:0] cmpb_data,
    output logic             pwm_a,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             soc,
    output logic             cmpb_match,
    output logic             pend_a,
    output logic             pend_b
);
    localparam int N_CMP = 2;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    logic             zero_evt;
    logic [CNT_W-1:0] cnt_w;
    logic             dir_w;
    logic             wr_vec   [N_CMP];
    logic [CNT_W-1:0] data_vec [N_CMP];
    logic [CNT_W-1:0] work_vec [N_CMP];
    logic             pend_vec [N_CMP];

    assign wr_vec[IDX_A]   = cmpa_wr;
    assign wr_vec[IDX_B]   = cmpb_wr;
    assign data_vec[IDX_A] = cmpa_data;
    assign data_vec[IDX_B] = cmpb_data;

    cpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tb_en),
        .period   (period),
        .count    (cnt_w),
        .dir_down (dir_w),
        .zero_evt (zero_evt)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        cpwm_cmpbuf #(.CNT_W(CNT_W)) u_cmpbuf (
            .clk         (clk),
            .rst_n       (rst_n),
            .shadow_mode (shadow_mode),
            .wr          (wr_vec[g]),
            .wdata       (data_vec[g]),
            .load_evt    (zero_evt),
            .active      (work_vec[g]),
            .pending     (pend_vec[g])
        );
    end

    cpwm_action #(.CNT_W(CNT_W)) u_action_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tb_en),
        .count    (cnt_w),
        .dir_down (dir_w),
        .period   (period),
        .cmp      (work_vec[IDX_A]),
        .pwm      (pwm_a)
    );

    assign count      = cnt_w;
    assign dir_down   = dir_w;
    assign soc        = zero_evt;
    assign cmpb_match = tb_en && (cnt_w == work_vec[IDX_B]);
    assign pend_a     = pend_vec[IDX_A];
    assign pend_b     = pend_vec[IDX_B];

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (count == '0 && !dir_down && !pwm_a && !pend_a && !pend_b));
endmodule

// File: tb/test_cpwm_core.sv
module test_cpwm_core;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tb_en = 1'b0;
    logic [W-1:0] period = '0;
    logic         shadow_mode = 1'b1;
    logic         cmpa_wr = 1'b0;
    logic [W-1:0] cmpa_data = '0;
    logic         cmpb_wr = 1'b0;
    logic [W-1:0] cmpb_data = '0;
    logic         pwm_a, dir_down, soc, cmpb_match, pend_a, pend_b;
    logic [W-1:0] count;

    cpwm_core #(.CNT_W(W)) i_cpwm_core (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .period(period),
        .shadow_mode(shadow_mode), .cmpa_wr(cmpa_wr), .cmpa_data(cmpa_data),
        .cmpb_wr(cmpb_wr), .cmpb_data(cmpb_data), .pwm_a(pwm_a), .count(count),
        .dir_down(dir_down), .soc(soc), .cmpb_match(cmpb_match),
        .pend_a(pend_a), .pend_b(pend_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int cnt; int dir; int pwm; int soc; int bm; int pa; int pb;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_cnt = 0, m_dir = 0, m_pwm = 0;
    int m_act_a = 0, m_sh_a = 0, m_p_a = 0;
    int m_act_b = 0, m_sh_b = 0, m_p_b = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic buf_step(input int ld, input int wr, input int d,
                            inout int act, inout int sh, inout int p);
        if (ld != 0 && p != 0) begin act = sh; p = 0; end
        if (wr != 0) begin
            if (shadow_mode) begin sh = d; p = 1; end
            else begin act = d; sh = d; p = 0; end
        end
    endtask

    // Reference model built from R2..R10; pushes values due after the next edge
    task automatic model_step();
        int P, nc, nd, np, ld, clr;
        exp_t e;
        P = int'(period);
        nc = m_cnt; nd = m_dir; np = m_pwm;
        ld = (tb_en && m_cnt == 0) ? 1 : 0;
        if (tb_en) begin
            clr = (m_act_a >= P) ? P : m_act_a;
            if (m_dir == 0 && m_cnt == m_act_a && m_act_a < P) np = 1;
            else if (m_dir == 1 && m_cnt == clr) np = 0;
            if (m_dir == 0) begin
                if (P == 0) begin nc = 0; nd = 0; end
                else if (m_cnt >= P) begin nc = m_cnt - 1; nd = (nc != 0); end
                else begin nc = m_cnt + 1; nd = (nc >= P); end
            end else begin
                if (m_cnt <= 1) begin nc = 0; nd = 0; end
                else begin nc = m_cnt - 1; nd = 1; end
            end
        end
        buf_step(ld, int'(cmpa_wr), int'(cmpa_data), m_act_a, m_sh_a, m_p_a);
        buf_step(ld, int'(cmpb_wr), int'(cmpb_data), m_act_b, m_sh_b, m_p_b);
        m_cnt = nc; m_dir = nd; m_pwm = np;
        e.cnt = nc; e.dir = nd; e.pwm = np;
        e.soc = (tb_en && nc == 0) ? 1 : 0;
        e.bm  = (tb_en && nc == m_act_b) ? 1 : 0;
        e.pa  = m_p_a; e.pb = m_p_b;
        exp_q.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        @(posedge clk);
        #(CLK_PERIOD*3/10);
    endtask

    task automatic wait_soc();
        do tick(); while (soc !== 1'b1);
    endtask

    task automatic measure(output int hi, output int ns, output int nb);
        hi = 0; ns = 0; nb = 0;
        for (int i = 0; i < 2*int'(period); i++) begin
            hi += int'(pwm_a); ns += int'(soc); nb += int'(cmpb_match);
            tick();
        end
    endtask

    task automatic write_a(input int v);
        cmpa_data = W'(v); cmpa_wr = 1'b1;
        tick();
        cmpa_wr = 1'b0;
    endtask

    // Monitor: pops the scoreboard after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/5);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk("R2", "count", int'(count), e.cnt);
                chk("R2", "dir_down", int'(dir_down), e.dir);
                chk("R4", "pwm_a", int'(pwm_a), e.pwm);
                chk("R9", "soc", int'(soc), e.soc);
                chk("R10", "cmpb_match", int'(cmpb_match), e.bm);
                chk("R8", "pend_a", int'(pend_a), e.pa);
                chk("R8", "pend_b", int'(pend_b), e.pb);
            end
        end
    end

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            chk("R2", "watchdog expired", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int hi, ns, nb, c0, p0, d0;
        period = W'(10);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD*3/10);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "count", int'(count), 0);
        chk("R1", "dir_down", int'(dir_down), 0);
        chk("R1", "pwm_a", int'(pwm_a), 0);
        chk("R1", "pend_a", int'(pend_a), 0);
        chk("R1", "pend_b", int'(pend_b), 0);
        chk("R1", "cmpb_match", int'(cmpb_match), 0);

        // R3/R8: buffered writes while stopped
        write_a(4);
        chk("R8", "pend_a after write", int'(pend_a), 1);
        cmpb_data = W'(7); cmpb_wr = 1'b1; tick(); cmpb_wr = 1'b0;
        repeat (3) tick();
        chk("R3", "count stopped", int'(count), 0);

        // R4/R9/R10 steady duty with C=4, B=7
        tb_en = 1'b1;
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R4", "high cycles C=4", hi, 12);
        chk("R9", "soc per cycle", ns, 1);
        chk("R10", "B matches per cycle", nb, 2);
        chk("R8", "pend_a after load", int'(pend_a), 0);

        // R6: two buffered writes mid-cycle, last wins
        repeat (3) tick();
        write_a(2);
        write_a(8);
        chk("R8", "pend_a pending", int'(pend_a), 1);
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R6", "high cycles after last write 8", hi, 4);

        // R7: direct write drops a pending buffered value
        repeat (2) tick();
        write_a(9);
        shadow_mode = 1'b0;
        write_a(5);
        chk("R7", "pend_a cleared by direct write", int'(pend_a), 0);
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R7", "high cycles C=5", hi, 10);

        // R5: extremes
        write_a(0);
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R5", "high cycles C=0", hi, 20);
        write_a(10);
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R5", "high cycles C=P", hi, 0);
        write_a(15);
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R5", "high cycles C>P", hi, 0);

        // R3: freeze mid-cycle with output high
        shadow_mode = 1'b1;
        write_a(3);
        wait_soc(); wait_soc();
        repeat (8) tick();
        tb_en = 1'b0;
        tick();
        c0 = int'(count); p0 = int'(pwm_a); d0 = int'(dir_down);
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R3", "count held", int'(count), c0);
            chk("R3", "pwm_a held", int'(pwm_a), p0);
            chk("R3", "dir held", int'(dir_down), d0);
        end
        tb_en = 1'b1;

        // R4 with a new period, R10 with B out of reach
        wait_soc();
        tb_en = 1'b0;
        repeat (2) tick();
        period = W'(6);
        write_a(3);
        tb_en = 1'b1;
        wait_soc(); wait_soc();
        measure(hi, ns, nb);
        chk("R4", "high cycles P=6 C=3", hi, 6);
        chk("R9", "soc per cycle P=6", ns, 1);
        chk("R10", "B above P never matches", nb, 0);

        repeat (2) tick();
        done = 1;
        summary();
        $finish;
    end
endmodule